// File: doc/BRIEF.md
# 100 Mbps Nibble-to-Code-Group Transmit Framer

This block turns the per-cycle transmit nibbles of a 100 Mbps media-independent interface into 5-bit code groups for the physical coding sublayer. It samples `tx_en`, `tx_er` and `txd` on each rising clock edge and emits one registered code group per cycle. With no frame in progress it sends the idle group. When a frame starts, the first two nibbles (always preamble) are overwritten by the start delimiter pair, so the symbol stream is as long as the nibble stream. After that each nibble is mapped through the 4B/5B table. A nibble flagged by `tx_er` becomes the error group instead. When `tx_en` drops, the end delimiter pair goes out and then idle resumes.

A receive-side decoder sits next to the encoder. It decodes either the block's own transmit stream (loopback) or a code group supplied on `rx_sym_i`. It returns the data nibble, a flag for control groups, and an error flag with a fixed nibble pattern for anything that is not a valid data or control group.

Top module: `nib5b_framer`

## Requirements
- R1: While `rst_n` is low (sampled at a clock edge), `sym_o` is 11111 and `rx_nib_o`, `rx_err_o` and `rx_ctl_o` are all zero.
- R2: With no frame in progress and `tx_en` low at an edge, `sym_o` after that edge is idle, 11111. Code groups are written MSB first as bits [4:0] of `sym_o`.
- R3: The first nibble sampled with `tx_en` high outside a frame produces 11000 (J) after that edge. The next sampled nibble produces 10001 (K), whatever its data value and whatever the state of `tx_er`.
- R4: From the third nibble of a frame on, each nibble d with `tx_er` low produces its 4B/5B group after the sampling edge. The groups for 0..F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: A data-phase nibble sampled with `tx_er` high produces 00100 (H) in place of its data group.
- R6: The first edge after a frame's data phase that samples `tx_en` low produces 01101 (T). The next edge produces 00111 (R), and idle follows.
- R7: A frame of n ≥ 2 nibbles yields exactly n symbols from J through the last data group, followed by T and R.
- R8: A frame of a single nibble produces J, K, T, R and then idle.
- R9: A nibble sampled in the cycle that R is being produced is discarded. A frame may begin with the very next nibble, which produces J.
- R10: The decoder maps each of the 16 data groups of R4 back to its nibble, with `rx_err_o` and `rx_ctl_o` low, one cycle after the group is presented.
- R11: The decoder reports 11111, 11000, 10001, 01101 and 00111 with `rx_ctl_o` high, `rx_err_o` low and nibble 0000.
- R12: Any other 5-bit value, including 00100, sets `rx_err_o` high with nibble 1110 and `rx_ctl_o` low.
- R13: With `lpbk` high the decoder input is `sym_o`. With `lpbk` low it is `rx_sym_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one nibble per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Frame in progress |
| tx_er | input | 1 | Current nibble is to be sent as an error group |
| txd | input | 4 | Transmit nibble |
| sym_o | output | 5 | Registered transmit code group |
| lpbk | input | 1 | Decoder source select: 1 = own transmit stream |
| rx_sym_i | input | 5 | External code group for the decoder |
| rx_nib_o | output | 4 | Decoded nibble |
| rx_err_o | output | 1 | Invalid or error code group |
| rx_ctl_o | output | 1 | Idle or delimiter code group |

## Verification
The bench builds the block with its default registered decoder, so every decoded result lands exactly one cycle behind the group it came from. That fixed one-cycle lag lets every transmitted symbol be checked again through the loopback path. With the decoder fed from the external input, all 32 five-bit values are swept, which covers every data, control and invalid group. On the transmit side, one long frame walks all 16 nibble values through the data phase. Shorter frames cover error injection, `tx_er` during the K slot, the single-nibble frame, and a restart during the R cycle.

// File: rtl/nib5b_pkg.sv
package nib5b_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = 5;

  localparam logic [SYM_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R    = 5'b00111;
  localparam logic [SYM_W-1:0] CG_H    = 5'b00100;
  localparam logic [NIB_W-1:0] ERR_NIB = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K    = 3'd1,
    ST_DATA = 3'd2,
    ST_T    = 3'd3,
    ST_R    = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic             err;
    logic             ctl;
    logic [NIB_W-1:0] nib;
  } dec_res_t;

  // 4B/5B data mapping
  function automatic logic [SYM_W-1:0] enc_nibble(input logic [NIB_W-1:0] d);
    logic [SYM_W-1:0] g;
    case (d)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction

  // Inverse mapping with control and error classification
  function automatic dec_res_t dec_group(input logic [SYM_W-1:0] g);
    dec_res_t r;
    r.err = 1'b0;
    r.ctl = 1'b0;
    r.nib = '0;
    case (g)
      5'b11110: r.nib = 4'h0;
      5'b01001: r.nib = 4'h1;
      5'b10100: r.nib = 4'h2;
      5'b10101: r.nib = 4'h3;
      5'b01010: r.nib = 4'h4;
      5'b01011: r.nib = 4'h5;
      5'b01110: r.nib = 4'h6;
      5'b01111: r.nib = 4'h7;
      5'b10010: r.nib = 4'h8;
      5'b10011: r.nib = 4'h9;
      5'b10110: r.nib = 4'hA;
      5'b10111: r.nib = 4'hB;
      5'b11010: r.nib = 4'hC;
      5'b11011: r.nib = 4'hD;
      5'b11100: r.nib = 4'hE;
      5'b11101: r.nib = 4'hF;
      CG_IDLE, CG_J, CG_K, CG_T, CG_R: r.ctl = 1'b1;
      default: begin
        r.err = 1'b1;
        r.nib = ERR_NIB;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/nib5b_tx_seq.sv
module nib5b_tx_seq
  import nib5b_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] txd,
  output logic [SYM_W-1:0] sym_o,
  output logic             sof_evt,
  output logic             eof_evt,
  output logic             data_ph,
  output logic             idle_ph
);
  tx_state_e        st_q, st_d;
  logic [SYM_W-1:0] sym_q, sym_d;

  always_comb begin
    st_d  = st_q;
    sym_d = CG_IDLE;
    case (st_q)
      ST_IDLE: begin
        if (tx_en) begin
          sym_d = CG_J;
          st_d  = ST_K;
        end
      end
      ST_K: begin
        sym_d = CG_K;
        st_d  = tx_en ? ST_DATA : ST_T;
      end
      ST_DATA: begin
        if (tx_en) begin
          sym_d = tx_er ? CG_H : enc_nibble(txd);
        end else begin
          sym_d = CG_T;
          st_d  = ST_R;
        end
      end
      ST_T: begin
        sym_d = CG_T;
        st_d  = ST_R;
      end
      ST_R: begin
        sym_d = CG_R;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sym_q <= CG_IDLE;
    end else begin
      st_q  <= st_d;
      sym_q <= sym_d;
    end
  end

  assign sym_o   = sym_q;
  assign idle_ph = (st_q == ST_IDLE);
  assign data_ph = (st_q == ST_DATA);
  assign sof_evt = idle_ph && tx_en;
  assign eof_evt = data_ph && !tx_en;
endmodule

// File: rtl/nib5b_rx_dec.sv
module nib5b_rx_dec
  import nib5b_pkg::*;
#(
  parameter bit DEC_REG = 1'b1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] grp_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             err_o,
  output logic             ctl_o
);
  dec_res_t res;
  assign res = dec_group(grp_i);

  generate
    if (DEC_REG) begin : g_reg
      dec_res_t res_q;
      always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res;
      end
      assign nib_o = res_q.nib;
      assign err_o = res_q.err;
      assign ctl_o = res_q.ctl;
    end else begin : g_comb
      assign nib_o = res.nib;
      assign err_o = res.err;
      assign ctl_o = res.ctl;
    end
  endgenerate
endmodule

// File: rtl/nib5b_framer.sv
module nib5b_framer
  import nib5b_pkg::*;
#(
  parameter bit DEC_REG = 1'b1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] txd,
  output logic [SYM_W-1:0] sym_o,
  input  logic             lpbk,
  input  logic [SYM_W-1:0] rx_sym_i,
  output logic [NIB_W-1:0] rx_nib_o,
  output logic             rx_err_o,
  output logic             rx_ctl_o
);
  logic             sof_evt, eof_evt, data_ph, idle_ph;
  logic [SYM_W-1:0] dec_src;

  nib5b_tx_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .tx_er   (tx_er),
    .txd     (txd),
    .sym_o   (sym_o),
    .sof_evt (sof_evt),
    .eof_evt (eof_evt),
    .data_ph (data_ph),
    .idle_ph (idle_ph)
  );

  assign dec_src = lpbk ? sym_o : rx_sym_i;

  nib5b_rx_dec #(.DEC_REG(DEC_REG)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .grp_i (dec_src),
    .nib_o (rx_nib_o),
    .err_o (rx_err_o),
    .ctl_o (rx_ctl_o)
  );
endmodule

// File: rtl/nib5b_framer_chk.sv
module nib5b_framer_chk
  import nib5b_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             tx_er,
  input logic [SYM_W-1:0] sym_o,
  input logic             sof_evt,
  input logic             eof_evt,
  input logic             data_ph,
  input logic             idle_ph,
  input logic [NIB_W-1:0] rx_nib_o,
  input logic             rx_err_o,
  input logic             rx_ctl_o
);
  // R2
  idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ph && !tx_en) |=> (sym_o == CG_IDLE));

  // R3
  start_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_evt |=> (sym_o == CG_J));

  // R3
  start_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_evt |=> ##1 (sym_o == CG_K));

  // R5
  err_subst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ph && tx_en && tx_er) |=> (sym_o == CG_H));

  // R6
  end_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_evt |=> (sym_o == CG_T) ##1 (sym_o == CG_R));

  // R12
  err_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_o |-> (rx_nib_o == ERR_NIB && !rx_ctl_o));

  // R11
  ctl_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ctl_o |-> (!rx_err_o && rx_nib_o == '0));
endmodule

bind nib5b_framer nib5b_framer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en    (tx_en),
  .tx_er    (tx_er),
  .sym_o    (sym_o),
  .sof_evt  (sof_evt),
  .eof_evt  (eof_evt),
  .data_ph  (data_ph),
  .idle_ph  (idle_ph),
  .rx_nib_o (rx_nib_o),
  .rx_err_o (rx_err_o),
  .rx_ctl_o (rx_ctl_o)
);

// File: tb/tb_nib5b_framer.sv
module tb_nib5b_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, tx_er = 1'b0, lpbk = 1'b1;
  logic [3:0] txd = '0;
  logic [4:0] rx_sym_i = '0;
  logic [4:0] sym_o;
  logic [3:0] rx_nib_o;
  logic       rx_err_o, rx_ctl_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [4:0] prev_sym = 5'b11111;

  // Code groups for nibbles F down to 0, five bits each
  localparam logic [79:0] ENC_TBL = {
    5'b11101, 5'b11100, 5'b11011, 5'b11010, 5'b10111, 5'b10110, 5'b10011, 5'b10010,
    5'b01111, 5'b01110, 5'b01011, 5'b01010, 5'b10101, 5'b10100, 5'b01001, 5'b11110};
  localparam logic [4:0] G_I = 5'b11111, G_J = 5'b11000, G_K = 5'b10001,
                         G_T = 5'b01101, G_R = 5'b00111, G_H = 5'b00100;

  always #2.5 clk = ~clk;

  nib5b_framer dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .sym_o(sym_o), .lpbk(lpbk), .rx_sym_i(rx_sym_i),
    .rx_nib_o(rx_nib_o), .rx_err_o(rx_err_o), .rx_ctl_o(rx_ctl_o));

  function automatic logic [4:0] tb_enc(input int v);
    return ENC_TBL[v*5 +: 5];
  endfunction

  // returns {err, ctl, nib}
  function automatic logic [5:0] tb_dec(input logic [4:0] g);
    for (int i = 0; i < 16; i++)
      if (tb_enc(i) == g) return {2'b00, 4'(i)};
    if (g == G_I || g == G_J || g == G_K || g == G_T || g == G_R) return 6'b010000;
    return 6'b101110;
  endfunction

  task automatic cmp(input logic [5:0] got, input logic [5:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input logic en, input logic er, input logic [3:0] d,
                      input logic [4:0] exp, input string tag);
    @(negedge clk);
    tx_en = en; tx_er = er; txd = d;
    @(posedge clk);
    #1;
    cmp({1'b0, sym_o}, {1'b0, exp}, tag);
    // R13 loopback: decoder reflects the previous transmit symbol
    cmp({rx_err_o, rx_ctl_o, rx_nib_o}, tb_dec(prev_sym), "R13 loopback");
    prev_sym = exp;
  endtask

  task automatic run_frame(input int n, input int er_at, input int dbase);
    for (int k = 0; k < n; k++) begin
      logic [3:0] d;
      d = 4'((dbase + k) % 16);
      if (k == 0)          step(1'b1, k == er_at, d, G_J, "R3 J");
      else if (k == 1)     step(1'b1, k == er_at, d, G_K, "R3 K");
      else if (k == er_at) step(1'b1, 1'b1, d, G_H, "R5 H");
      else                 step(1'b1, 1'b0, d, tb_enc(int'(d)), "R4 data");
    end
    step(1'b0, 1'b0, 4'h0, G_T, "R6/R7 T");
    step(1'b0, 1'b0, 4'h0, G_R, "R6 R");
    step(1'b0, 1'b0, 4'h0, G_I, "R2 idle");
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    cmp({1'b0, sym_o}, {1'b0, G_I}, "R1 sym");
    cmp({rx_err_o, rx_ctl_o, rx_nib_o}, 6'b000000, "R1 rx");
    @(negedge clk);
    rst_n = 1'b1;

    // R2: idle between frames
    step(1'b0, 1'b0, 4'h5, G_I, "R2 idle");
    step(1'b0, 1'b1, 4'hA, G_I, "R2 idle");

    // R4 / R7: all 16 nibble values in the data phase
    run_frame(18, -1, 14);
    // R5: error injection mid-frame
    run_frame(7, 4, 3);
    // R3: tx_er in the K slot has no effect
    run_frame(4, 1, 9);

    // R8: single-nibble frame
    step(1'b1, 1'b0, 4'h5, G_J, "R8 J");
    step(1'b0, 1'b0, 4'h0, G_K, "R8 K");
    step(1'b0, 1'b0, 4'h0, G_T, "R8 T");
    step(1'b0, 1'b0, 4'h0, G_R, "R8 R");
    step(1'b0, 1'b0, 4'h0, G_I, "R8 idle");

    // R9: nibble during R discarded, next one starts a frame
    step(1'b1, 1'b0, 4'h5, G_J, "R9 J");
    step(1'b1, 1'b0, 4'h5, G_K, "R9 K");
    step(1'b1, 1'b0, 4'h3, tb_enc(3), "R9 data");
    step(1'b0, 1'b0, 4'h0, G_T, "R9 T");
    step(1'b1, 1'b0, 4'h5, G_R, "R9 R");
    step(1'b1, 1'b0, 4'h6, G_J, "R9 J restart");
    step(1'b1, 1'b0, 4'h6, G_K, "R9 K restart");
    step(1'b1, 1'b0, 4'h7, tb_enc(7), "R9 data");
    step(1'b0, 1'b0, 4'h0, G_T, "R9 T");
    step(1'b0, 1'b0, 4'h0, G_R, "R9 R");
    step(1'b0, 1'b0, 4'h0, G_I, "R9 idle");

    // R10 R11 R12 R13: external source, all 32 values
    @(negedge clk);
    lpbk = 1'b0;
    for (int v = 0; v < 32; v++) begin
      @(negedge clk);
      rx_sym_i = 5'(v);
      @(posedge clk);
      #1;
      cmp({rx_err_o, rx_ctl_o, rx_nib_o}, tb_dec(5'(v)), "R10/R11/R12 decode");
      cmp({1'b0, sym_o}, {1'b0, G_I}, "R13 tx unaffected");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule